// File: doc/BRIEF.md
# Programmable Watchdog Reset Timer

This block is a watchdog. Software programs an 8-bit timeout count in units of seconds or minutes and then sets the run bit. A prescaler divides a 1 kHz tick, and each completed unit lowers the count by one. If software does not rewrite the timeout value in time, the count reaches zero. The block then raises a sticky expiry flag and can drive a reset pin. A second sticky flag gives early warning: it rises while one unit is still left.

The reset pin's behaviour is set in the registers:

- Its active level can be high or low.
- It can hold its level until software clears the expiry flag, or it can emit one pulse of 1 ms, 25 ms, 125 ms or 5 s.
- A separate output-enable bit decides whether an expiry reaches the pin at all.

The 1 kHz tick comes from one of two pins, chosen by a register bit. Each tick source is synchronized into the system clock domain and reduced to a one-cycle pulse on its rising edge.

Access is through a simple write strobe, a 2-bit address and an 8-bit write/read data pair. Reads are combinational from the selected register.

Top module: `wdog_timer_top`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00, the timeout register (address 1) reads 0x00 and the auxiliary register (address 2) reads 0x02. The reset pin is inactive, which under the reset polarity (active-low) means 1, and `warn_o` is 0.
- R2: Control register field layout:
  - bit 0 run
  - bit 1 unit (0 = second, 1 = minute)
  - bit 2 pulse mode
  - bit 3 active-high
  - bits 5:4 pulse-width code
  - bit 7 expiry flag
- R2 (continued): Auxiliary register field layout:
  - bit 0 output enable
  - bit 1 external tick select
  - bit 2 warning enable
  - bit 7 warning flag
- R2 (continued): The timeout register holds the written 8-bit value. Writable fields read back as written.
- R3: While run is 1, the count decrements once every TICKS_PER_SEC ticks. When it reaches zero, the expiry flag (control bit 7) sets.
- R4: Writing 1 to control bit 7 clears the expiry flag. Writing 0 there leaves it unchanged.
- R5: While run is 0, ticks do not change the count and no expiry occurs.
- R6: A timeout value of 0 with run set expires at once, within two clock cycles of the write.
- R7: In level mode with output enable set, the reset pin is active while the expiry flag is set. Active means 1 when active-high is set and 0 otherwise. The pin returns to inactive once the flag is cleared.
- R8: With warning enable set, auxiliary bit 7 and `warn_o` set while the running count equals 1. The flag is sticky, and writing 1 to auxiliary bit 7 clears it.
- R9: With output enable 0, an expiry never drives the reset pin active.
- R10: Writing the timeout register reloads the count and restarts the prescaler, which postpones expiry.
- R11: With the unit bit set, one count lasts TICKS_PER_SEC*SEC_PER_MIN ticks.
- R12: In pulse mode with output enable set, an expiry drives the pin active for exactly the number of ticks that the pulse-width code selects. Codes 0 to 3 map to PULSE_W0 to PULSE_W3.
- R13: With auxiliary bit 1 at 0, only `tick_int_i` advances the timer. At 1, only `tick_ext_i` advances it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_int_i | input | 1 | Internal 1 kHz tick source |
| tick_ext_i | input | 1 | External 1 kHz tick source |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| wdt_rst_o | output | 1 | Reset output, polarity per control bit 3 |
| warn_o | output | 1 | Early-warning flag |

## Verification
Register writes are visible on `rdata_o` in the cycle after the write strobe. An expiry caused by a write (a zero timeout) sets the flag one cycle later still.

A tick edge takes two synchronizer cycles plus one edge-detect cycle before the count moves. The resulting expiry appears in the flag and on the pin one cycle after that.

The bench holds each tick high for three cycles and low for three. It samples only at a falling clock edge after that window, and a register is checked only from the clock edge after its write has completed. The scoreboard therefore compares every value after its latency has passed, never in the cycle it changes.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_TIME = 2'd1;
    localparam logic [1:0] ADDR_AUX  = 2'd2;

    typedef struct packed {
        logic       run;
        logic       unit_min;
        logic       pulse_mode;
        logic       act_high;
        logic [1:0] pw_sel;
        logic       out_en;
        logic       ext_sel;
        logic       warn_en;
    } wdog_cfg_t;

endpackage

// File: rtl/wdog_tick_sync.sv
module wdog_tick_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_int_i,
    input  logic tick_ext_i,
    input  logic ext_sel_i,
    output logic tick_o
);
    localparam int NSRC = 2;

    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] edge_hit;

    assign raw = {tick_ext_i, tick_int_i};

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        logic [SYNC_STAGES:0] shift_d, shift_q;

        always_comb begin
            shift_d = {shift_q[SYNC_STAGES-1:0], raw[s]};
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) shift_q <= '0;
            else         shift_q <= shift_d;
        end

        assign edge_hit[s] = shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];

        assert_edge_single_R13 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            edge_hit[s] |=> !edge_hit[s]);
    end

    assign tick_o = ext_sel_i ? edge_hit[1] : edge_hit[0];

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wr_en_i,
    input  logic [1:0]  addr_i,
    input  logic [7:0]  wdata_i,
    input  logic        expire_i,
    input  logic        warn_hit_i,
    output wdog_cfg_t   cfg_o,
    output logic        load_o,
    output logic        exp_flag_o,
    output logic        warn_flag_o,
    output logic [7:0]  rdata_o
);
    typedef struct packed {
        wdog_cfg_t  cfg;
        logic [7:0] tmo;
        logic       exp_flag;
        logic       warn_flag;
    } regs_state_t;

    regs_state_t st_d, st_q;
    logic wr_ctrl, wr_time, wr_aux;

    always_comb begin
        wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
        wr_time = wr_en_i && (addr_i == ADDR_TIME);
        wr_aux  = wr_en_i && (addr_i == ADDR_AUX);

        st_d = st_q;
        if (wr_ctrl) begin
            st_d.cfg.run        = wdata_i[0];
            st_d.cfg.unit_min   = wdata_i[1];
            st_d.cfg.pulse_mode = wdata_i[2];
            st_d.cfg.act_high   = wdata_i[3];
            st_d.cfg.pw_sel     = wdata_i[5:4];
        end
        if (wr_aux) begin
            st_d.cfg.out_en  = wdata_i[0];
            st_d.cfg.ext_sel = wdata_i[1];
            st_d.cfg.warn_en = wdata_i[2];
        end
        if (wr_time) st_d.tmo = wdata_i;

        if (expire_i)                    st_d.exp_flag = 1'b1;
        else if (wr_ctrl && wdata_i[7])  st_d.exp_flag = 1'b0;

        if (warn_hit_i && st_q.cfg.warn_en) st_d.warn_flag = 1'b1;
        else if (wr_aux && wdata_i[7])      st_d.warn_flag = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q             <= '0;
            st_q.cfg.ext_sel <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (addr_i)
            ADDR_CTRL: rdata_o = {st_q.exp_flag, 1'b0, st_q.cfg.pw_sel, st_q.cfg.act_high,
                                  st_q.cfg.pulse_mode, st_q.cfg.unit_min, st_q.cfg.run};
            ADDR_TIME: rdata_o = st_q.tmo;
            ADDR_AUX:  rdata_o = {st_q.warn_flag, 4'b0000, st_q.cfg.warn_en,
                                  st_q.cfg.ext_sel, st_q.cfg.out_en};
            default:   rdata_o = 8'h00;
        endcase
    end

    assign cfg_o       = st_q.cfg;
    assign load_o      = wr_time;
    assign exp_flag_o  = st_q.exp_flag;
    assign warn_flag_o = st_q.warn_flag;

    assert_expiry_sets_flag_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_i |=> st_q.exp_flag);

    assert_flag_w1c_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_ctrl && wdata_i[7] && !expire_i) |=> !st_q.exp_flag);

    assert_warn_needs_enable_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_q.cfg.warn_en && !st_q.warn_flag) |=> !st_q.warn_flag);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int TICKS_PER_SEC = 1000,
    parameter int SEC_PER_MIN   = 60
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       run_i,
    input  logic       unit_min_i,
    input  logic       load_i,
    input  logic [7:0] load_val_i,
    output logic       expire_o,
    output logic       warn_hit_o
);
    localparam int MIN_TICKS = TICKS_PER_SEC * SEC_PER_MIN;
    localparam int PRESC_W   = (MIN_TICKS > 1) ? $clog2(MIN_TICKS) : 1;

    typedef struct packed {
        logic [7:0]         cnt;
        logic [PRESC_W-1:0] presc;
        logic               fired;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [PRESC_W-1:0] last_step;
    logic               expire;

    always_comb begin
        last_step = unit_min_i ? PRESC_W'(MIN_TICKS - 1) : PRESC_W'(TICKS_PER_SEC - 1);
        expire    = run_i && (st_q.cnt == 8'd0) && !st_q.fired;

        st_d = st_q;
        if (load_i) begin
            st_d.cnt   = load_val_i;
            st_d.presc = '0;
            st_d.fired = 1'b0;
        end else if (!run_i) begin
            st_d.presc = '0;
            st_d.fired = 1'b0;
        end else begin
            if (expire) st_d.fired = 1'b1;
            if (tick_i && (st_q.cnt != 8'd0)) begin
                if (st_q.presc >= last_step) begin
                    st_d.presc = '0;
                    st_d.cnt   = st_q.cnt - 8'd1;
                end else begin
                    st_d.presc = st_q.presc + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign expire_o   = expire;
    assign warn_hit_o = run_i && (st_q.cnt == 8'd1);

    assert_halt_when_stopped_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !load_i) |=> $stable(st_q.cnt));

    assert_no_wrap_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cnt == 8'd0 && !load_i) |=> (st_q.cnt == 8'd0));

    assert_reload_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (st_q.cnt == $past(load_val_i)));

endmodule

// File: rtl/wdog_out_shaper.sv
module wdog_out_shaper #(
    parameter int PULSE_W0 = 1,
    parameter int PULSE_W1 = 25,
    parameter int PULSE_W2 = 125,
    parameter int PULSE_W3 = 5000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       expire_i,
    input  logic       exp_flag_i,
    input  logic       pulse_mode_i,
    input  logic       out_en_i,
    input  logic       act_high_i,
    input  logic [1:0] pw_sel_i,
    output logic       pin_o
);
    localparam int MAX01 = (PULSE_W0 > PULSE_W1) ? PULSE_W0 : PULSE_W1;
    localparam int MAX23 = (PULSE_W2 > PULSE_W3) ? PULSE_W2 : PULSE_W3;
    localparam int PW_MAX = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int CW = $clog2(PW_MAX + 1);

    typedef struct packed {
        logic [CW-1:0] left;
    } shp_state_t;

    shp_state_t st_d, st_q;
    logic [CW-1:0] len;
    logic          active;

    always_comb begin
        unique case (pw_sel_i)
            2'd0:    len = CW'(PULSE_W0);
            2'd1:    len = CW'(PULSE_W1);
            2'd2:    len = CW'(PULSE_W2);
            default: len = CW'(PULSE_W3);
        endcase

        st_d = st_q;
        if (expire_i && out_en_i && pulse_mode_i) st_d.left = len;
        else if (tick_i && (st_q.left != '0))     st_d.left = st_q.left - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        active = pulse_mode_i ? (st_q.left != '0) : (out_en_i && exp_flag_i);
        pin_o  = act_high_i ? active : ~active;
    end

    assert_pulse_starts_R12 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (expire_i && out_en_i && pulse_mode_i) |=> (st_q.left != '0));

    assert_pulse_steady_R12 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !expire_i) |=> $stable(st_q.left));

endmodule

// File: rtl/wdog_timer_top.sv
module wdog_timer_top
    import wdog_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1000,
    parameter int SEC_PER_MIN   = 60,
    parameter int SYNC_STAGES   = 2,
    parameter int PULSE_W0      = 1,
    parameter int PULSE_W1      = 25,
    parameter int PULSE_W2      = 125,
    parameter int PULSE_W3      = 5000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_int_i,
    input  logic       tick_ext_i,
    input  logic       wr_en_i,
    input  logic [1:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       wdt_rst_o,
    output logic       warn_o
);
    wdog_cfg_t cfg;
    logic tick, load, expire, warn_hit, exp_flag;

    wdog_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_int_i (tick_int_i),
        .tick_ext_i (tick_ext_i),
        .ext_sel_i  (cfg.ext_sel),
        .tick_o     (tick)
    );

    wdog_regs u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (wr_en_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .expire_i    (expire),
        .warn_hit_i  (warn_hit),
        .cfg_o       (cfg),
        .load_o      (load),
        .exp_flag_o  (exp_flag),
        .warn_flag_o (warn_o),
        .rdata_o     (rdata_o)
    );

    wdog_counter #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .SEC_PER_MIN   (SEC_PER_MIN)
    ) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick),
        .run_i      (cfg.run),
        .unit_min_i (cfg.unit_min),
        .load_i     (load),
        .load_val_i (wdata_i),
        .expire_o   (expire),
        .warn_hit_o (warn_hit)
    );

    wdog_out_shaper #(
        .PULSE_W0 (PULSE_W0),
        .PULSE_W1 (PULSE_W1),
        .PULSE_W2 (PULSE_W2),
        .PULSE_W3 (PULSE_W3)
    ) u_out (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (tick),
        .expire_i     (expire),
        .exp_flag_i   (exp_flag),
        .pulse_mode_i (cfg.pulse_mode),
        .out_en_i     (cfg.out_en),
        .act_high_i   (cfg.act_high),
        .pw_sel_i     (cfg.pw_sel),
        .pin_o        (wdt_rst_o)
    );

    assert_gated_pin_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cfg.pulse_mode && !cfg.out_en) |-> (wdt_rst_o == !cfg.act_high));

endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_top_tb_top;
    localparam int TPS = 3;
    localparam int SPM = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_int = 1'b0;
    logic       tick_ext = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       wdt_rst;
    logic       warn;

    always #5 clk = ~clk;

    wdog_timer_top #(
        .TICKS_PER_SEC (TPS),
        .SEC_PER_MIN   (SPM),
        .SYNC_STAGES   (2),
        .PULSE_W0      (1),
        .PULSE_W1      (2),
        .PULSE_W2      (3),
        .PULSE_W3      (4)
    ) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .tick_int_i (tick_int),
        .tick_ext_i (tick_ext),
        .wr_en_i    (wr_en),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .wdt_rst_o  (wdt_rst),
        .warn_o     (warn)
    );

    typedef struct {
        string      req;
        int         kind;   // 0: rdata, 1: reset pin, 2: warn_o
        logic [7:0] exp;
    } sb_item_t;

    sb_item_t sb[$];
    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            sb_item_t it;
            logic [7:0] got;
            it  = sb.pop_front();
            got = (it.kind == 1) ? {7'b0, wdt_rst} : (it.kind == 2) ? {7'b0, warn} : rdata;
            n_run++;
            if (got !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got %0h expected %0h", it.req, got, it.exp);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic expect_item(input string req, input int kind, input logic [1:0] a,
                               input logic [7:0] e);
        sb_item_t it;
        @(posedge clk); #1;
        addr = a;
        it.req = req; it.kind = kind; it.exp = e;
        sb.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic ticks(input int n, input bit ext);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            if (ext) tick_ext = 1'b1; else tick_int = 1'b1;
            repeat (3) @(posedge clk);
            #1;
            tick_ext = 1'b0; tick_int = 1'b0;
            repeat (3) @(posedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_item("R1 ctrl", 0, 2'd0, 8'h00);
        expect_item("R1 time", 0, 2'd1, 8'h00);
        expect_item("R1 aux",  0, 2'd2, 8'h02);
        expect_item("R1 pin",  1, 2'd0, 8'h01);
        expect_item("R1 warn", 2, 2'd0, 8'h00);

        // R2 field readback
        wr(2'd0, 8'h3E); expect_item("R2 ctrl", 0, 2'd0, 8'h3E);
        wr(2'd2, 8'h07); expect_item("R2 aux",  0, 2'd2, 8'h07);
        wr(2'd1, 8'hA5); expect_item("R2 time", 0, 2'd1, 8'hA5);
        wr(2'd0, 8'h00);

        // R6 zero timeout, R9 gated pin
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h01);
        expect_item("R6 immediate", 0, 2'd0, 8'h81);
        expect_item("R9 gated",     1, 2'd0, 8'h01);

        // R4 write-one-to-clear
        wr(2'd0, 8'h01); expect_item("R4 zero keeps", 0, 2'd0, 8'h81);
        wr(2'd0, 8'h81); expect_item("R4 one clears", 0, 2'd0, 8'h01);
        wr(2'd0, 8'h00);

        // R3 R7 R8 seconds count, level active-high, warning
        wr(2'd2, 8'h05);
        wr(2'd1, 8'h02);
        wr(2'd0, 8'h09);
        expect_item("R7 idle pin", 1, 2'd0, 8'h00);
        ticks(TPS - 1, 1'b0);
        expect_item("R8 not yet", 0, 2'd2, 8'h05);
        ticks(1, 1'b0);
        expect_item("R8 warn flag", 0, 2'd2, 8'h85);
        expect_item("R8 warn_o",    2, 2'd0, 8'h01);
        ticks(TPS - 1, 1'b0);
        expect_item("R3 not yet", 0, 2'd0, 8'h09);
        expect_item("R7 pin idle", 1, 2'd0, 8'h00);
        ticks(1, 1'b0);
        expect_item("R3 expired", 0, 2'd0, 8'h89);
        expect_item("R7 pin high", 1, 2'd0, 8'h01);
        wr(2'd0, 8'h89);
        expect_item("R7 pin released", 1, 2'd0, 8'h00);
        wr(2'd2, 8'h85);
        expect_item("R8 cleared", 0, 2'd2, 8'h05);
        wr(2'd0, 8'h08);

        // R5 stopped timer ignores ticks
        wr(2'd1, 8'h01);
        ticks(5, 1'b0);
        expect_item("R5 stopped", 0, 2'd0, 8'h08);
        wr(2'd0, 8'h09);
        ticks(TPS - 1, 1'b0);
        expect_item("R5 resumed no expiry", 0, 2'd0, 8'h09);
        ticks(1, 1'b0);
        expect_item("R5 resumed expiry", 0, 2'd0, 8'h89);
        wr(2'd0, 8'h88);
        wr(2'd2, 8'h85);

        // R10 kick reload
        wr(2'd1, 8'h02);
        wr(2'd0, 8'h09);
        ticks(TPS, 1'b0);
        wr(2'd1, 8'h02);
        ticks(TPS, 1'b0);
        expect_item("R10 postponed", 0, 2'd0, 8'h09);
        ticks(TPS, 1'b0);
        expect_item("R10 expired", 0, 2'd0, 8'h89);
        wr(2'd0, 8'h88);
        wr(2'd2, 8'h85);

        // R11 minute unit
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h0B);
        ticks(TPS * SPM - 1, 1'b0);
        expect_item("R11 not yet", 0, 2'd0, 8'h0B);
        ticks(1, 1'b0);
        expect_item("R11 expired", 0, 2'd0, 8'h8B);
        wr(2'd0, 8'h8A);
        wr(2'd2, 8'h85);

        // R12 pulse mode, code 2 = 3 ticks, active-low
        wr(2'd2, 8'h01);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h25);
        expect_item("R12 pulse start", 1, 2'd0, 8'h00);
        expect_item("R12 flag", 0, 2'd0, 8'hA5);
        ticks(2, 1'b0);
        expect_item("R12 pulse held", 1, 2'd0, 8'h00);
        ticks(1, 1'b0);
        expect_item("R12 pulse end", 1, 2'd0, 8'h01);
        wr(2'd0, 8'h80);

        // R13 tick source select
        wr(2'd2, 8'h02);
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h01);
        ticks(5, 1'b0);
        expect_item("R13 internal ignored", 0, 2'd0, 8'h01);
        ticks(TPS, 1'b1);
        expect_item("R13 external counts", 0, 2'd0, 8'h81);

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule